// File: doc/BRIEF.md
# Configurable Counter and Delay Cell

This block is a small timing cell with an 8-bit count register. It works in one of two modes. As a periodic counter it marks every N-th tick of a chosen count clock. As a delay generator it holds back each level change of a data input until N ticks of the count clock have passed since the change was seen. In delay mode an extra output can also emit a one-cycle pulse on a chosen edge of the data input, sent out alongside the delayed level.

All logic runs on one system clock. The count clock is a one-cycle enable taken from one of several sources:
- an oscillator tick input;
- that tick divided by 4, 12, 24, 64 or 4096;
- the rising edges of an external clock level;
- the rising edges of a chain input.

Feeding one cell's output into the next cell's chain input builds a longer count or delay. The reset is asserted asynchronously and released through a two-stage synchronizer. Mode, edge selection and count value are static configuration that is changed while the cell is held in reset. The source selection may change at any time.

Top module: `cnt_dly_cell`

## Requirements
- R1: While reset is asserted, and right after it is released, `dout` and `pulse_out` are 0.
- R2: `cfg_src` encoding: 0 = oscillator tick, 1 = tick/4, 2 = tick/12, 3 = tick/24, 4 = tick/64, 5 = tick/4096, 6 = external clock, 7 = chain input. The count register moves only on cycles of the selected count tick.
- R3: Counter mode (`cfg_mode` = 1). The first count tick after reset loads N. After that, `dout` goes high on every N-th tick and stays high until the next tick, so the period is N ticks and the high time is one tick.
- R4: A divided source (codes 1 to 5) gives one count tick on every R-th oscillator tick, where R is its ratio.
- R5: The external clock and chain sources count only the rising edges of their level. Falling edges have no effect.
- R6: Delay mode (`cfg_mode` = 0). The first cycle in which `din` differs from `dout` starts a countdown. `dout` takes the new level on the N-th count tick after that cycle.
- R7: In delay mode, if `din` returns to the `dout` level before the countdown expires, the pending change is dropped and `dout` does not move.
- R8: `cfg_edge` selects the pulse edge: 00 = rising, 01 = falling, 10 = both, 11 = off. `pulse_out` is high for exactly the one system cycle after the edge is sampled.
- R9: In counter mode `pulse_out` stays 0 whatever `din` does.
- R10: A `cfg_value` of 0 acts as N = 1.
- R11: A change of `cfg_src` restarts the divider. The oscillator tick in the change cycle is ignored, and the first divided tick comes on the R-th oscillator tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator enable |
| ext_clk | input | 1 | External clock level, synchronous |
| chain_in | input | 1 | Output of the preceding cell |
| din | input | 1 | Data input for delay mode |
| cfg_mode | input | 1 | 0 = delay, 1 = counter |
| cfg_src | input | 3 | Count clock source select |
| cfg_edge | input | 2 | Pulse edge select |
| cfg_value | input | 8 | Programmed count N |
| dout | output | 1 | Counter terminal output or delayed level |
| pulse_out | output | 1 | One-cycle edge pulse |

## Verification
Counter mode is driven from every source code at several count values, and both the period and the high time of `dout` are measured. The period shows the divide ratio multiplied by N. The high time shows the length of a single count tick, so swapped ratios or miscounted edges give different results. Delay mode is driven with a clean step, a step that reverts before expiry, and a source switch at the moment of the step. These separate the expiry cycle, cancellation and divider restart. Each pulse edge code is tried with both edge directions.

// File: rtl/cnt_dly_pkg.sv
package cnt_dly_pkg;
  typedef enum logic [2:0] {
    SRC_OSC   = 3'd0,
    SRC_DIV_A = 3'd1,
    SRC_DIV_B = 3'd2,
    SRC_DIV_C = 3'd3,
    SRC_DIV_D = 3'd4,
    SRC_DIV_E = 3'd5,
    SRC_EXT   = 3'd6,
    SRC_CHAIN = 3'd7
  } src_e;

  typedef enum logic {
    MODE_DELAY = 1'b0,
    MODE_COUNT = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cnt_dly_prescaler.sv
module cnt_dly_prescaler
  import cnt_dly_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 12,
  parameter int DIV_C = 24,
  parameter int DIV_D = 64,
  parameter int DIV_E = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [2:0] src,
  output logic       div_en
);
  localparam int RMAX = max_of(max_of(max_of(DIV_A, DIV_B), max_of(DIV_C, DIV_D)), DIV_E);
  localparam int PW   = $clog2(RMAX);

  logic [PW-1:0] pcnt_q, pcnt_d, lim;
  logic [2:0]    src_q;
  logic          changed, term;

  always_comb begin
    unique case (src_e'(src))
      SRC_DIV_A: lim = PW'(DIV_A - 1);
      SRC_DIV_B: lim = PW'(DIV_B - 1);
      SRC_DIV_C: lim = PW'(DIV_C - 1);
      SRC_DIV_D: lim = PW'(DIV_D - 1);
      SRC_DIV_E: lim = PW'(DIV_E - 1);
      default:   lim = '0;
    endcase
  end

  assign changed = (src != src_q);
  assign term    = (pcnt_q == lim);
  assign div_en  = osc_tick & term & ~changed;

  always_comb begin
    pcnt_d = pcnt_q;
    if (changed)       pcnt_d = '0;
    else if (osc_tick) pcnt_d = term ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      src_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      src_q  <= src;
    end
  end
endmodule

// File: rtl/cnt_dly_rise_det.sv
module cnt_dly_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/cnt_dly_edge_pulse.sv
module cnt_dly_edge_pulse
  import cnt_dly_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       dly_mode,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic din_q, pulse_d, rise, fall;

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;

  always_comb begin
    pulse_d = 1'b0;
    if (dly_mode) begin
      unique case (edge_e'(sel))
        EDGE_RISE: pulse_d = rise;
        EDGE_FALL: pulse_d = fall;
        EDGE_BOTH: pulse_d = rise | fall;
        default:   pulse_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      din_q <= din;
      pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/cnt_dly_core.sv
module cnt_dly_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         count_mode,
  input  logic         din,
  input  logic [W-1:0] value,
  output logic         dout
);
  logic [W-1:0] load, cnt_q, cnt_d;
  logic         out_d;

  assign load = (value == '0) ? W'(1) : value;

  always_comb begin
    cnt_d = cnt_q;
    out_d = dout;
    if (count_mode) begin
      if (cnt_en) begin
        out_d = (cnt_q == W'(1));
        cnt_d = (cnt_q <= W'(1)) ? load : cnt_q - 1'b1;
      end
    end else if (din == dout) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d = load;
    end else if (cnt_en) begin
      if (cnt_q == W'(1)) begin
        out_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dout  <= out_d;
    end
  end
endmodule

// File: rtl/cnt_dly_cell.sv
module cnt_dly_cell
  import cnt_dly_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 12,
  parameter int DIV_C = 24,
  parameter int DIV_D = 64,
  parameter int DIV_E = 4096
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         osc_tick,
  input  logic         ext_clk,
  input  logic         chain_in,
  input  logic         din,
  input  logic         cfg_mode,
  input  logic [2:0]   cfg_src,
  input  logic [1:0]   cfg_edge,
  input  logic [W-1:0] cfg_value,
  output logic         dout,
  output logic         pulse_out
);
  localparam int NLVL = 2;

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            div_en, cnt_en;
  logic [NLVL-1:0] lvl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cnt_dly_prescaler #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D), .DIV_E(DIV_E)
  ) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .osc_tick(osc_tick), .src(cfg_src), .div_en(div_en)
  );

  cnt_dly_rise_det #(.N(NLVL)) u_rise (
    .clk(clk), .rst_n(rst_sync_n), .lvl({chain_in, ext_clk}), .rise(lvl_rise)
  );

  always_comb begin
    unique case (src_e'(cfg_src))
      SRC_OSC:   cnt_en = osc_tick;
      SRC_EXT:   cnt_en = lvl_rise[0];
      SRC_CHAIN: cnt_en = lvl_rise[1];
      default:   cnt_en = div_en;
    endcase
  end

  cnt_dly_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .count_mode(cfg_mode),
    .din(din), .value(cfg_value), .dout(dout)
  );

  cnt_dly_edge_pulse u_pulse (
    .clk(clk), .rst_n(rst_sync_n), .din(din), .dly_mode(cfg_mode == MODE_DELAY),
    .sel(cfg_edge), .pulse(pulse_out)
  );
endmodule

// File: rtl/cnt_dly_cell_chk.sv
module cnt_dly_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       din,
  input logic       cfg_mode,
  input logic [2:0] cfg_src,
  input logic       cnt_en,
  input logic       dout,
  input logic       pulse_out
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  // R1: outputs low while held in reset
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> (!dout && !pulse_out));

  // R8: a pulse only follows a sampled change of din
  a_r8_pulse_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && pulse_out) |-> ($past(din) != $past(din, 2)));

  // R9: no pulse in counter mode
  a_r9_no_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(cfg_mode)) |-> !pulse_out);

  // R6: in delay mode the output moves only on a count tick, towards din
  a_r6_delay_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !cfg_mode && !$past(cfg_mode) && dout != $past(dout))
    |-> ($past(cnt_en) && dout == $past(din)));

  // R3: counter output rises only on a count tick
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(cfg_mode) && $rose(dout)) |-> $past(cnt_en));

  // R11: a divided source gives no tick in the cycle its selection changes
  a_r11_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && cfg_src != $past(cfg_src) && cfg_src >= 3'd1 && cfg_src <= 3'd5)
    |-> !cnt_en);
endmodule

bind cnt_dly_cell cnt_dly_cell_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .din(din), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
  .cnt_en(cnt_en), .dout(dout), .pulse_out(pulse_out)
);

// File: tb/sim_cnt_dly_cell.sv
`timescale 1ns/1ps
module sim_cnt_dly_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, ext_clk = 1'b0, chain_in = 1'b0, din = 1'b0;
  logic cfg_mode = 1'b0;
  logic [2:0] cfg_src = 3'd0;
  logic [1:0] cfg_edge = 2'b00;
  logic [7:0] cfg_value = 8'd4;
  logic dout, pulse_out;

  int n_chk = 0, n_fail = 0;
  int osc_per = 1, ext_per = 4;
  int gcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cnt_dly_cell u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_clk(ext_clk),
    .chain_in(chain_in), .din(din), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
    .cfg_edge(cfg_edge), .cfg_value(cfg_value), .dout(dout), .pulse_out(pulse_out)
  );

  always @(negedge clk) begin
    gcnt     = gcnt + 1;
    osc_tick = ((gcnt % osc_per) == 0);
    ext_clk  = ((gcnt % ext_per) < (ext_per / 2));
    chain_in = ext_clk;
  end

  typedef struct packed {
    logic [2:0]  src;
    logic [7:0]  val;
    logic [7:0]  osc;
    logic [7:0]  ext;
    logic [15:0] per;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    {3'd0, 8'd5,   8'd1, 8'd4, 16'd5,    16'd1},
    {3'd1, 8'd3,   8'd1, 8'd4, 16'd12,   16'd4},
    {3'd2, 8'd2,   8'd1, 8'd4, 16'd24,   16'd12},
    {3'd3, 8'd2,   8'd1, 8'd4, 16'd48,   16'd24},
    {3'd4, 8'd3,   8'd1, 8'd4, 16'd192,  16'd64},
    {3'd5, 8'd2,   8'd1, 8'd4, 16'd8192, 16'd4096},
    {3'd0, 8'd255, 8'd1, 8'd4, 16'd255,  16'd1},
    {3'd0, 8'd2,   8'd3, 8'd4, 16'd6,    16'd3},
    {3'd6, 8'd4,   8'd1, 8'd6, 16'd24,   16'd6},
    {3'd7, 8'd3,   8'd1, 8'd4, 16'd12,   16'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic mode, input logic [2:0] src,
                          input logic [7:0] val, input logic [1:0] edg);
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b0;
    cfg_mode = mode; cfg_src = src; cfg_value = val; cfg_edge = edg;
    step();
    check("R1 dout in reset", dout, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic measure(output int hi, output int per);
    int lim;
    lim = 0;
    hi = 0; per = 0;
    while (dout !== 1'b1 && lim < 20000) begin step(); lim++; end
    while (dout === 1'b1 && lim < 40000) begin step(); hi++; lim++; end
    per = hi;
    while (dout !== 1'b1 && lim < 60000) begin step(); per++; lim++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, per;

    // R1: outputs after reset
    do_reset(1'b0, 3'd0, 8'd4, 2'b00);
    check("R1 dout after reset", dout, 0);
    check("R1 pulse after reset", pulse_out, 0);

    // Table: counter mode over the source codes (R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      osc_per = int'(VEC[i].osc);
      ext_per = int'(VEC[i].ext);
      do_reset(1'b1, VEC[i].src, VEC[i].val, 2'b00);
      measure(hi, per);
      check($sformatf("R2 R3 R4 R5 period vec %0d", i), per, int'(VEC[i].per));
      check($sformatf("R3 high time vec %0d", i), hi, int'(VEC[i].hi));
    end
    osc_per = 1; ext_per = 4;

    // R6 / R8: delay with N = 4, rising pulse
    do_reset(1'b0, 3'd0, 8'd4, 2'b00);
    @(negedge clk); din = 1'b1;
    step();
    check("R8 rising pulse", pulse_out, 1);
    check("R6 dout held at start", dout, 0);
    step();
    check("R8 pulse one cycle", pulse_out, 0);
    step(); step();
    check("R6 dout before expiry", dout, 0);
    step();
    check("R6 dout at expiry", dout, 1);

    // R7: revert before expiry cancels
    @(negedge clk); din = 1'b0;
    step(); step();
    @(negedge clk); din = 1'b1;
    repeat (6) step();
    check("R7 cancelled change", dout, 1);

    // R8: falling select
    @(negedge clk); cfg_edge = 2'b01; din = 1'b0;
    step();
    check("R8 falling pulse", pulse_out, 1);
    repeat (6) step();
    @(negedge clk); din = 1'b1;
    step();
    check("R8 falling ignores rise", pulse_out, 0);
    repeat (6) step();

    // R8: both edges
    @(negedge clk); cfg_edge = 2'b10; din = 1'b0;
    step();
    check("R8 both on fall", pulse_out, 1);
    repeat (6) step();
    @(negedge clk); din = 1'b1;
    step();
    check("R8 both on rise", pulse_out, 1);
    repeat (6) step();

    // R8: off
    @(negedge clk); cfg_edge = 2'b11; din = 1'b0;
    step();
    check("R8 off no pulse", pulse_out, 0);
    repeat (6) step();

    // R10: value 0 acts as 1
    do_reset(1'b0, 3'd0, 8'd0, 2'b00);
    @(negedge clk); din = 1'b1;
    step();
    check("R10 dout at start", dout, 0);
    step();
    check("R10 dout after one tick", dout, 1);

    // R11: divider restart on source change
    do_reset(1'b0, 3'd2, 8'd1, 2'b00);
    repeat (7) step();
    @(negedge clk); cfg_src = 3'd1; din = 1'b1;
    step();
    repeat (3) step();
    check("R11 no tick before ratio", dout, 0);
    step();
    check("R11 tick on fourth osc tick", dout, 1);

    // R9: no pulse in counter mode
    do_reset(1'b1, 3'd0, 8'd200, 2'b10);
    @(negedge clk); din = 1'b1;
    step();
    check("R9 no pulse rise", pulse_out, 0);
    @(negedge clk); din = 1'b0;
    step();
    check("R9 no pulse fall", pulse_out, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule